// File: doc/BRIEF.md
# Flash Power-State and Output-Drive Controller

This block decides, cycle by cycle, whether a flash behavioural model is active, in standby or in automatic sleep. It watches chip enable, the hardware reset pin, output enable, the address bus and a busy flag raised by the program/erase engine. From these it drives the data-bus output enable, a capture enable for the output data register and a data-valid flag that marks when read data may be used.

Sleep depends only on how long the address has stayed unchanged. A cycle counter restarts on every address change. When it reaches the access time plus a 50 ns margin, both given in clock cycles, the block enters sleep and freezes the output register. Standby follows deselection or a low reset pin. A deselect that arrives while a program or erase is still running is held off until the operation ends. After standby or an address change, data-valid stays low for the chip-enable or the address access time.

Top module: `flash_pwr_ctrl`

## Requirements
- R1: While `rst_n` is low, `pwr_state` is 1 (standby) and `dq_drive`, `data_valid` and `dout_latch_en` are all 0.
- R2: When `ce_n` is high, `hw_reset_n` is high and `op_busy` is low, `pwr_state` is 1 from the next rising edge. `dq_drive` and `data_valid` are then 0, whatever `oe_n` is.
- R3: When `hw_reset_n` is low, `pwr_state` is 1 from the next rising edge, whatever `ce_n` and `op_busy` are.
- R4: A high `ce_n` sampled together with a high `op_busy` does not move the block into standby. It moves to standby on the first edge that samples `op_busy` low with `ce_n` still high.
- R5: `pwr_state` encodes 0 = active, 1 = standby, 2 = sleep. `dq_drive` is 1 exactly when `pwr_state` is not 1 and both `ce_n` and `oe_n` are low.
- R6: With SLEEP_CYC = T_ACC_CYC + T_50NS_CYC, `pwr_state` becomes 2 at the SLEEP_CYC-th edge after the edge that captured the last address change. Sleep is never entered while `data_valid` is 0; in that case it is entered on the first edge after `data_valid` has risen.
- R7: During sleep `data_valid` stays 1 and `dout_latch_en` stays 0, so the last read data is held.
- R8: Toggling `oe_n` while the address is stable neither delays nor advances sleep entry.
- R9: An address change leaves sleep: `pwr_state` is 0 and `data_valid` is 0 from the next edge, and `data_valid` returns to 1 T_ACC_CYC edges later. `dout_latch_en` is 1 exactly when `pwr_state` is 0 and `data_valid` is 1.
- R10: On leaving standby, `data_valid` rises T_CE_CYC edges after the edge at which `pwr_state` first reads 0.
- R11: An address change during a pending address access restarts the wait to a full T_ACC_CYC edges from the capturing edge. A longer remaining standby-exit wait is kept.
- R12: Every address change restarts the stability count, so an earlier pending sleep entry is cancelled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock |
| rst_n | input | 1 | Synchronous model reset, active low |
| ce_n | input | 1 | Chip enable, active low |
| hw_reset_n | input | 1 | Hardware reset pin, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Address bus |
| op_busy | input | 1 | Program or erase in progress |
| pwr_state | output | 2 | 0 active, 1 standby, 2 sleep |
| dq_drive | output | 1 | Data bus output enable |
| dout_latch_en | output | 1 | Capture enable for the output data register |
| data_valid | output | 1 | Read data may be used |

## Verification
The assertions assume the inputs change only between clock edges and that the address is a clean bus value sampled once per cycle. They also assume `op_busy` only rises while the chip is selected, so a busy flag never appears out of standby without an access. The stimulus drives every input one nanosecond after a falling edge. It raises `op_busy` only together with or after an address change, and keeps T_ACC_CYC and T_50NS_CYC at least 1 so that the sleep and access windows are never empty.

// File: rtl/flash_pwr_ctrl.sv
module flash_pwr_ctrl #(
  parameter int ADDR_W     = 21,
  parameter int T_ACC_CYC  = 10,
  parameter int T_50NS_CYC = 5,
  parameter int T_CE_CYC   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              hw_reset_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              op_busy,
  output logic [1:0]        pwr_state,
  output logic              dq_drive,
  output logic              dout_latch_en,
  output logic              data_valid
);
  localparam int SLEEP_CYC = T_ACC_CYC + T_50NS_CYC;
  localparam int CW        = $clog2(SLEEP_CYC + 1);
  localparam int WMAX      = (T_CE_CYC + 1 > T_ACC_CYC) ? T_CE_CYC + 1 : T_ACC_CYC;
  localparam int DW        = $clog2(WMAX + 1);
  localparam logic [CW-1:0] STAB_TOP = CW'(SLEEP_CYC);
  localparam logic [CW-1:0] STAB_HIT = CW'(SLEEP_CYC - 1);
  localparam logic [DW-1:0] CE_LOAD  = DW'(T_CE_CYC + 1);
  localparam logic [DW-1:0] ACC_LOAD = DW'(T_ACC_CYC);
  localparam logic [1:0] ST_ACT   = 2'd0;
  localparam logic [1:0] ST_STBY  = 2'd1;
  localparam logic [1:0] ST_SLEEP = 2'd2;

  logic [ADDR_W-1:0] addr_q;
  logic [CW-1:0]     stab_q, stab_d;
  logic [DW-1:0]     wait_q, wait_d;
  logic [1:0]        state_q, state_d;

  wire addr_chg = addr != addr_q;
  wire stby_req = !hw_reset_n || (ce_n && !op_busy);
  wire in_stby  = state_q == ST_STBY;
  wire sleep_ok = !addr_chg && stab_q >= STAB_HIT && wait_q == '0;

  always_comb begin
    if (stby_req)      state_d = ST_STBY;
    else if (addr_chg) state_d = ST_ACT;
    else if (sleep_ok) state_d = ST_SLEEP;
    else               state_d = ST_ACT;
  end

  always_comb begin
    if (stby_req || addr_chg)  stab_d = '0;
    else if (stab_q < STAB_TOP) stab_d = stab_q + 1'b1;
    else                       stab_d = stab_q;
  end

  always_comb begin
    if (stby_req)            wait_d = CE_LOAD;
    else if (addr_chg)       wait_d = (wait_q > ACC_LOAD) ? wait_q - 1'b1 : ACC_LOAD;
    else if (wait_q != '0)   wait_d = wait_q - 1'b1;
    else                     wait_d = wait_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_STBY;
      stab_q  <= '0;
      wait_q  <= CE_LOAD;
      addr_q  <= addr;
    end else begin
      state_q <= state_d;
      stab_q  <= stab_d;
      wait_q  <= wait_d;
      addr_q  <= addr;
    end
  end

  assign pwr_state     = state_q;
  assign data_valid    = !in_stby && wait_q == '0;
  assign dout_latch_en = state_q == ST_ACT && data_valid;
  assign dq_drive      = !in_stby && !ce_n && !oe_n;

  a_r2_idle_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n && hw_reset_n && !op_busy) |=> (pwr_state == ST_STBY && !dq_drive && !data_valid));

  a_r3_pin_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !hw_reset_n |=> pwr_state == ST_STBY);

  a_r4_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n && op_busy && hw_reset_n && pwr_state != ST_STBY) |=> pwr_state != ST_STBY);

  a_r6_sleep_after_stable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_state == ST_SLEEP) |-> $past(addr, 1) == $past(addr, 2));

  a_r7_sleep_holds_data: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_state == ST_SLEEP |-> (data_valid && !dout_latch_en));

  a_r9_addr_wakes: assert property (@(posedge clk) disable iff (!rst_n)
    (addr != addr_q && !stby_req) |=> (pwr_state == ST_ACT && !data_valid));
endmodule

// File: tb/flash_pwr_ctrl_tb_top.sv
`timescale 1ns/100ps
module flash_pwr_ctrl_tb_top;
  localparam int AW    = 12;
  localparam int TACC  = 4;
  localparam int T50   = 3;
  localparam int TCE   = 6;
  localparam int SLEEP = TACC + T50;
  localparam logic [1:0] ACT = 2'd0, STBY = 2'd1, SLP = 2'd2;

  logic clk = 1'b0;
  logic rst_n = 1'b0, ce_n = 1'b1, hw_reset_n = 1'b1, oe_n = 1'b1, op_busy = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [1:0] pwr_state;
  logic dq_drive, dout_latch_en, data_valid;

  always #2.5 clk = ~clk;

  flash_pwr_ctrl #(.ADDR_W(AW), .T_ACC_CYC(TACC), .T_50NS_CYC(T50), .T_CE_CYC(TCE)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .hw_reset_n(hw_reset_n), .oe_n(oe_n),
    .addr(addr), .op_busy(op_busy), .pwr_state(pwr_state), .dq_drive(dq_drive),
    .dout_latch_en(dout_latch_en), .data_valid(data_valid));

  typedef struct {
    int         due;
    logic [1:0] st;
    logic       vld;
    logic       drv;
    logic       le;
    string      tag;
  } exp_t;

  exp_t sb[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].due == cyc) begin
        checks++;
        if (pwr_state !== sb[i].st || data_valid !== sb[i].vld ||
            dq_drive !== sb[i].drv || dout_latch_en !== sb[i].le) begin
          errors++;
          $display("FAIL %s cyc=%0d actual st=%0d vld=%0b drv=%0b le=%0b expected st=%0d vld=%0b drv=%0b le=%0b",
                   sb[i].tag, cyc, pwr_state, data_valid, dq_drive, dout_latch_en,
                   sb[i].st, sb[i].vld, sb[i].drv, sb[i].le);
        end
        sb.delete(i);
      end
    end
  end

  task automatic expect_in(int dly, logic [1:0] st, logic vld, logic drv, string tag);
    exp_t e;
    e.due = cyc + dly; e.st = st; e.vld = vld; e.drv = drv;
    e.le = (st == ACT) && vld; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    tick(3);
    expect_in(1, STBY, 0, 0, "R1");
    tick(1);
    rst_n = 1'b1; oe_n = 1'b0;
    expect_in(1, STBY, 0, 0, "R2");
    expect_in(3, STBY, 0, 0, "R2");
    tick(4);

    ce_n = 1'b0;
    expect_in(1, ACT, 0, 1, "R10");
    expect_in(TCE, ACT, 0, 1, "R10");
    expect_in(TCE + 1, ACT, 1, 1, "R10");
    expect_in(TCE + 2, SLP, 1, 1, "R6");
    tick(TCE + 2);
    oe_n = 1'b1;
    expect_in(1, SLP, 1, 0, "R7");
    tick(1);
    oe_n = 1'b0;
    expect_in(1, SLP, 1, 1, "R7");
    tick(1);

    addr = 12'h2A5;
    expect_in(1, ACT, 0, 1, "R9");
    expect_in(TACC, ACT, 0, 1, "R9");
    expect_in(TACC + 1, ACT, 1, 1, "R9");
    expect_in(SLEEP, ACT, 1, 1, "R6");
    expect_in(SLEEP + 1, SLP, 1, 1, "R6");
    tick(SLEEP + 2);

    addr = 12'h1F0;
    expect_in(SLEEP, ACT, 1, 1, "R8");
    expect_in(SLEEP + 1, SLP, 1, 1, "R8");
    for (int i = 1; i <= SLEEP + 1; i++) begin
      tick(1);
      oe_n = (i < SLEEP - 1) ? (i % 2 == 1) : 1'b0;
    end
    tick(1);

    addr = 12'h0A0;
    tick(3);
    addr = 12'h0A1;
    expect_in(1, ACT, 0, 1, "R11");
    expect_in(TACC, ACT, 0, 1, "R11");
    expect_in(TACC + 1, ACT, 1, 1, "R11");
    expect_in(SLEEP, ACT, 1, 1, "R12");
    expect_in(SLEEP + 1, SLP, 1, 1, "R12");
    tick(SLEEP + 2);

    addr = 12'h333; ce_n = 1'b1; op_busy = 1'b1;
    expect_in(1, ACT, 0, 0, "R4");
    expect_in(3, ACT, 0, 0, "R4");
    tick(3);
    op_busy = 1'b0;
    expect_in(1, STBY, 0, 0, "R4");
    tick(2);

    ce_n = 1'b0;
    tick(TCE + 1);
    hw_reset_n = 1'b0; op_busy = 1'b1;
    expect_in(1, STBY, 0, 0, "R3");
    expect_in(2, STBY, 0, 0, "R3");
    tick(2);
    hw_reset_n = 1'b1; op_busy = 1'b0;
    expect_in(1, ACT, 0, 1, "R10");
    expect_in(TCE + 1, ACT, 1, 1, "R10");
    tick(TCE + 3);
    oe_n = 1'b1;
    expect_in(1, SLP, 1, 0, "R5");
    tick(3);

    if (sb.size() != 0) begin
      errors++;
      $display("FAIL scoreboard actual %0d pending expected 0", sb.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule